// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block keeps one processor's reservation for a lock-free read-modify-write sequence on a shared-memory multiprocessor. Software reads a location with a load-locked request, changes the value in a register, then tries to write it back with a store-conditional request, and tests the returned status. The monitor records the block address named by the load-locked request and holds a reservation flag. The flag is cancelled by an interrupt, by an exception, or by a store from another processor that lands anywhere in the reserved block. A store-conditional commits its write only if the reservation is still intact and its address falls inside the reserved block. In every other case no write leaves the block and the status reports failure, so software repeats the whole sequence.

The reservation is a two-state machine. `RSV_EMPTY` moves to `RSV_HELD` on an *arm* transition, which is a load-locked request with no cancelling event in the same cycle. `RSV_HELD` stays in `RSV_HELD` on a *rearm* transition, which is a new load-locked request that replaces the recorded address. `RSV_HELD` returns to `RSV_EMPTY` on a *cancel* transition, caused by an interrupt, an exception or a matching snoop. It also returns to `RSV_EMPTY` on a *consume* transition, which is any store-conditional without a load-locked in the same cycle. The response path is a three-state machine. `RSP_IDLE` goes to `RSP_PASS` on a *grant* transition, or to `RSP_FAIL` on a *deny* transition, in the cycle after a store-conditional. Either state then returns to `RSP_IDLE`, or goes straight to another verdict when a new store-conditional follows. The block reports results one clock cycle after the request. Blocks are 16 bytes by default.

Top module: `llsc_resv_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, `resv_valid`, `sc_done` and `wr_en` are 0, and `sc_status` and `wr_addr` are 0.
- R2: A load-locked request with no interrupt, exception or matching snoop in the same cycle sets `resv_valid` to 1 in the next cycle.
- R3: A store-conditional to any address inside the reserved 16-byte block (address bits [31:4] equal), with the reservation held and no cancelling event in that cycle, gives in the next cycle `wr_en`=1, `wr_addr` and `wr_data` equal to the request, and `sc_status`=1.
- R4: A store-conditional when no reservation is held gives `sc_status`=0 and `wr_en`=0 in the next cycle.
- R5: An interrupt clears the reservation. An interrupt in the same cycle as the store-conditional also makes that store-conditional fail.
- R6: An exception clears the reservation in the same way as an interrupt, and a later store-conditional fails.
- R7: A snooped store to any byte of the reserved block clears the reservation, and a snooped store outside the block leaves it in place. A snoop that hits the block a same-cycle load-locked is reserving also leaves no reservation.
- R8: A store-conditional outside the reserved block fails with `sc_status`=0 and produces no write.
- R9: Every store-conditional clears `resv_valid` in the next cycle, whether it passes or fails, unless a load-locked request arrives in the same cycle.
- R10: A new load-locked request replaces the earlier reservation. A store-conditional to the old block then fails, and one to the new block succeeds.
- R11: `sc_done` is 1 for exactly one cycle per store-conditional. `sc_status` is 64 bits wide and holds the value 1 on success and 0 on failure, with all upper bits zero.
- R12: When a store-conditional and a load-locked request arrive in the same cycle, the store-conditional is judged against the old reservation, and the new load-locked address becomes the held reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-locked request |
| ll_addr | input | 32 | Physical address of the load-locked request |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | 32 | Physical address of the store-conditional |
| sc_data | input | 64 | Data the store-conditional would write |
| evt_irq | input | 1 | Interrupt taken this cycle |
| evt_exc | input | 1 | Exception taken this cycle |
| snoop_valid | input | 1 | Store by another agent observed this cycle |
| snoop_addr | input | 32 | Address of the observed store |
| resv_valid | output | 1 | Reservation flag |
| sc_done | output | 1 | Store-conditional verdict valid (one cycle) |
| sc_status | output | 64 | Value for the status register: 1 pass, 0 fail |
| wr_en | output | 1 | Committed store to memory |
| wr_addr | output | 32 | Address of the committed store |
| wr_data | output | 64 | Data of the committed store |

## Verification
The assertions check on every cycle the rules that depend only on one cycle of inputs. These rules are: arming after a clean load-locked, dropping the flag after any cancelling event or store-conditional, no write without a reservation, no write after an interrupt or exception, no write on a block miss, and the shape of the status word. The bench scenarios are the only way to show the behaviours that span many cycles. These behaviours are: a reservation that survives idle cycles and snoops to neighbouring blocks, replacement by a later load-locked, and the correct address and data on a committed write.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_PASS = 2'd1,
        RSP_FAIL = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/llsc_blk_cmp.sv
module llsc_blk_cmp #(
    parameter int ADDR_W   = 32,
    parameter int BLK_BITS = 4
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_blk
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_BITS) - ADDR_W'(1));

    always_comb begin
        same_blk = ((addr_a ^ addr_b) & BLK_MASK) == '0;
    end
endmodule

// File: rtl/llsc_rsv_fsm.sv
module llsc_rsv_fsm
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic              kill,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);
    rsv_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (ll_valid && !kill) state_d = RSV_HELD;     // arm
            end
            RSV_HELD: begin
                if (kill)          state_d = RSV_EMPTY;        // cancel
                else if (ll_valid) state_d = RSV_HELD;         // rearm
                else if (sc_valid) state_d = RSV_EMPTY;        // consume
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ll_valid) addr_q <= ll_addr;
        end
    end

    always_comb begin
        held      = (state_q == RSV_HELD);
        held_addr = addr_q;
    end

    AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ll_valid && !kill |=> held);                              // R2
    AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !held);                                          // R5
    AST_SC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !ll_valid |=> !held);                         // R9
endmodule

// File: rtl/llsc_sc_eval.sv
module llsc_sc_eval
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DATA_W-1:0] sc_data,
    input  logic              held,
    input  logic              sc_hit,
    input  logic              evt_irq,
    input  logic              evt_exc,
    input  logic              snoop_old_hit,
    output logic              sc_done,
    output logic [DATA_W-1:0] sc_status,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    rsp_state_e rsp_q, rsp_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              grant;

    always_comb begin
        grant = sc_valid && held && sc_hit && !evt_irq && !evt_exc && !snoop_old_hit;
        rsp_d = RSP_IDLE;
        unique case (rsp_q)
            RSP_IDLE, RSP_PASS, RSP_FAIL: begin
                if (sc_valid) rsp_d = grant ? RSP_PASS : RSP_FAIL;  // grant / deny
            end
            default: rsp_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q  <= RSP_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (sc_valid) begin
                addr_q <= sc_addr;
                data_q <= sc_data;
            end
        end
    end

    always_comb begin
        sc_done   = (rsp_q != RSP_IDLE);
        sc_status = DATA_W'(rsp_q == RSP_PASS);
        wr_en     = (rsp_q == RSP_PASS);
        wr_addr   = wr_en ? addr_q : '0;
        wr_data   = wr_en ? data_q : '0;
    end

    AST_NO_RESV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !held |=> !wr_en);                            // R4
    AST_EVT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && (evt_irq || evt_exc) |=> !wr_en);             // R5
    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !sc_hit |=> !wr_en);                          // R8
    AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_done);                                    // R11
    AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sc_done);                                       // R3
    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> sc_status[DATA_W-1:1] == '0);                 // R11
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 64,
    parameter int BLK_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DATA_W-1:0] sc_data,
    input  logic              evt_irq,
    input  logic              evt_exc,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              resv_valid,
    output logic              sc_done,
    output logic [DATA_W-1:0] sc_status,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic              held;
    logic [ADDR_W-1:0] held_addr;
    logic              sc_hit, snp_old_eq, snp_new_eq;
    logic              snoop_old_hit, snoop_kill, kill;

    llsc_blk_cmp #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_cmp_sc (
        .addr_a(sc_addr), .addr_b(held_addr), .same_blk(sc_hit));
    llsc_blk_cmp #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_cmp_snp_old (
        .addr_a(snoop_addr), .addr_b(held_addr), .same_blk(snp_old_eq));
    llsc_blk_cmp #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_cmp_snp_new (
        .addr_a(snoop_addr), .addr_b(ll_addr), .same_blk(snp_new_eq));

    always_comb begin
        snoop_old_hit = snoop_valid && held && snp_old_eq;
        snoop_kill    = ll_valid ? (snoop_valid && snp_new_eq) : snoop_old_hit;
        kill          = evt_irq || evt_exc || snoop_kill;
    end

    llsc_rsv_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .kill(kill), .held(held), .held_addr(held_addr));

    llsc_sc_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eval (
        .clk(clk), .rst_n(rst_n), .sc_valid(sc_valid), .sc_addr(sc_addr),
        .sc_data(sc_data), .held(held), .sc_hit(sc_hit), .evt_irq(evt_irq),
        .evt_exc(evt_exc), .snoop_old_hit(snoop_old_hit), .sc_done(sc_done),
        .sc_status(sc_status), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    assign resv_valid = held;

    AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_exc |=> !resv_valid);                                 // R6
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |=> !resv_valid);                                 // R5
    AST_SC_LL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && ll_valid && !evt_irq && !evt_exc && !snoop_valid |=> resv_valid); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done && !$past(sc_valid) |-> 1'b0);                    // R11
endmodule

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ll_valid = 1'b0, sc_valid = 1'b0;
    logic [31:0] ll_addr = '0, sc_addr = '0, snoop_addr = '0;
    logic [63:0] sc_data = '0;
    logic        evt_irq = 1'b0, evt_exc = 1'b0, snoop_valid = 1'b0;
    logic        resv_valid, sc_done, wr_en;
    logic [63:0] sc_status, wr_data;
    logic [31:0] wr_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        pass;
        logic [31:0] addr;
        logic [63:0] data;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    llsc_resv_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_data(sc_data),
        .evt_irq(evt_irq), .evt_exc(evt_exc), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .resv_valid(resv_valid), .sc_done(sc_done),
        .sc_status(sc_status), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected verdicts as the design reports them
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sc_done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected sc_done", 64'(sc_done), 64'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(sc_status == 64'(e.pass), e.req, "sc_status", sc_status, 64'(e.pass));
                    check(wr_en == e.pass, e.req, "wr_en", 64'(wr_en), 64'(e.pass));
                    if (e.pass) begin
                        check(wr_addr == e.addr, e.req, "wr_addr", 64'(wr_addr), 64'(e.addr));
                        check(wr_data == e.data, e.req, "wr_data", wr_data, e.data);
                    end
                end
            end else if (wr_en) begin
                check(1'b0, "R3", "wr_en without sc_done", 64'(wr_en), 64'h0);
            end
        end
    end

    // driver: one cycle of stimulus, pushes the expected verdict of a store-conditional
    task automatic drive(input logic ll, input logic [31:0] lla,
                         input logic sc, input logic [31:0] sca, input logic [63:0] scd,
                         input logic irq, input logic exc,
                         input logic sn, input logic [31:0] sna,
                         input logic exp_pass, input string req);
        ll_valid = ll; ll_addr = lla;
        sc_valid = sc; sc_addr = sca; sc_data = scd;
        evt_irq = irq; evt_exc = exc; snoop_valid = sn; snoop_addr = sna;
        if (sc) sb_q.push_back('{exp_pass, sca, scd, req});
        @(negedge clk);
        ll_valid = 1'b0; sc_valid = 1'b0; evt_irq = 1'b0; evt_exc = 1'b0; snoop_valid = 1'b0;
    endtask

    task automatic ll_op(input logic [31:0] a);
        drive(1, a, 0, '0, '0, 0, 0, 0, '0, 0, "");
    endtask
    task automatic sc_op(input logic [31:0] a, input logic [63:0] d,
                         input logic pass, input string req);
        drive(0, '0, 1, a, d, 0, 0, 0, '0, pass, req);
    endtask
    task automatic idle();
        drive(0, '0, 0, '0, '0, 0, 0, 0, '0, 0, "");
    endtask
    task automatic chk_resv(input logic exp, input string req);
        check(resv_valid == exp, req, "resv_valid", 64'(resv_valid), 64'(exp));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: held in reset
        check(!resv_valid && !sc_done && !wr_en && sc_status == 0 && wr_addr == 0,
              "R1", "outputs in reset", {resv_valid, sc_done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!resv_valid && !sc_done && !wr_en, "R1", "outputs after reset",
              {resv_valid, sc_done, wr_en}, 0);

        // R2, R3, R9: clean sequence
        ll_op(32'h1000);
        chk_resv(1, "R2");
        idle();
        chk_resv(1, "R2");
        sc_op(32'h1008, 64'hDEAD_BEEF_0123_4567, 1, "R3");
        chk_resv(0, "R9");
        idle();
        check(sc_done == 0, "R11", "sc_done single pulse", 64'(sc_done), 0);

        // R4: no reservation
        sc_op(32'h1008, 64'h11, 0, "R4");
        idle();

        // R5: interrupt between, and in same cycle as store-conditional
        ll_op(32'h2000);
        drive(0, '0, 0, '0, '0, 1, 0, 0, '0, 0, "");
        chk_resv(0, "R5");
        sc_op(32'h2000, 64'h22, 0, "R5");
        ll_op(32'h2000);
        drive(0, '0, 1, 32'h2004, 64'h23, 1, 0, 0, '0, 0, "R5");
        idle();

        // R6: exception
        ll_op(32'h2800);
        drive(0, '0, 0, '0, '0, 0, 1, 0, '0, 0, "");
        chk_resv(0, "R6");
        sc_op(32'h2800, 64'h28, 0, "R6");
        idle();

        // R7: snoops inside and outside the block
        ll_op(32'h3004);
        drive(0, '0, 0, '0, '0, 0, 0, 1, 32'h3010, 0, "");
        chk_resv(1, "R7");
        drive(0, '0, 0, '0, '0, 0, 0, 1, 32'h2FFF, 0, "");
        chk_resv(1, "R7");
        drive(0, '0, 0, '0, '0, 0, 0, 1, 32'h300F, 0, "");
        chk_resv(0, "R7");
        sc_op(32'h3004, 64'h33, 0, "R7");
        drive(1, 32'h3400, 0, '0, '0, 0, 0, 1, 32'h3408, 0, "");
        chk_resv(0, "R7");
        idle();

        // R8: outside the reserved block
        ll_op(32'h4000);
        sc_op(32'h4010, 64'h44, 0, "R8");
        chk_resv(0, "R9");
        idle();

        // R10: replacement
        ll_op(32'h5000);
        ll_op(32'h6000);
        sc_op(32'h5000, 64'h55, 0, "R10");
        ll_op(32'h5000);
        ll_op(32'h6000);
        sc_op(32'h600C, 64'h66, 1, "R10");
        idle();

        // R12: store-conditional with load-locked in the same cycle, back to back
        ll_op(32'h7000);
        drive(1, 32'h8000, 1, 32'h7000, 64'h77, 0, 0, 0, '0, 1, "R12");
        chk_resv(1, "R12");
        sc_op(32'h8008, 64'h88, 1, "R12");
        chk_resv(0, "R9");
        idle();
        idle();

        check(sb_q.size() == 0, "R11", "verdicts outstanding", 64'(sb_q.size()), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule